// File: doc/BRIEF.md
# TDM Serial Audio Receiver

This block turns a time-division-multiplexed serial audio line into a stream of 32-bit sample words. It watches a bit clock, a frame sync and a serial data line. These inputs may come from the chip's own transmitter or from an external clock master. All three are brought into the system clock domain, and the receiver acts on the bit-clock edge chosen by the polarity setting. Once a frame start is found, the block cuts the bit stream into slots of the programmed length. From each slot it keeps one justified word and pushes that word into a 32-entry FIFO. The FIFO has a valid/ready read port and a DMA request line with a selectable fill threshold.

The configuration pins are set to the same values as the transmitter's: slot length, word length, justification, sync shape, sync alignment and clock polarity. A frame carries a programmed number of slots. Bits that arrive after the last slot of a frame are ignored until the next frame sync.

Read-side back-pressure works as follows. `m_valid` is high whenever the FIFO holds a word, and `m_data` shows the oldest word. A word leaves only in a cycle where both `m_valid` and `m_ready` are high. While `m_ready` is low, `m_valid` and `m_data` stay unchanged. The serial side cannot be stalled, so a word that finds the FIFO full is lost and `overflow` records the loss.

Top module: `tdm_rx`

## Requirements
- R1: With `cfg_pol` = 0 the data and sync lines are sampled on falling bit-clock edges. With `cfg_pol` = 1 they are sampled on rising edges. A word is produced only in the cycle after a sampling edge.
- R2: `cfg_slot_len` selects the slot size: 0 for 8 bits, 1 for 16 bits, 2 or 3 for 32 bits. Data bits arrive MSB first.
- R3: `cfg_word_len` selects the word size: 0 for 8, 1 for 16, 2 for 20, 3 for 24 bits, and 4 to 7 for 32 bits. A word longer than its slot is cut to the slot length.
- R4: With `cfg_left_just` = 1 the word is taken from the first bits received in the slot. With 0 it is taken from the last bits received. The other bits of the slot are discarded.
- R5: After a frame start exactly `cfg_slots` slots are captured (1 to 8; 0 acts as 1). Any further bits are ignored until the next frame start.
- R6: A frame start is a sampled sync of 1 where the previous sample was 0. In long-sync mode (`cfg_long_sync` = 1), or in short mode with `cfg_early` = 1, the bit sampled with that start is bit 0 of slot 0. In short mode with `cfg_early` = 0, bit 0 is the next sampled bit. `cfg_early` has no effect in long mode.
- R7: While `rx_en` is 0 nothing is captured. After `rx_en` rises, all bits are discarded until the first frame start.
- R8: Each word enters the FIFO MSB-aligned in 32 bits, with all bits below the word zero.
- R9: The FIFO holds 32 words and delivers them in arrival order. While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold.
- R10: `dma_req` is 1 when the fill level is at least 16 (`cfg_quarter` = 0) or at least 8 (`cfg_quarter` = 1).
- R11: A word completed while the FIFO is full is dropped, and `overflow` becomes 1 and stays 1 until reset. Filling to exactly 32 does not set it.
- R12: A frame start that arrives before the frame has ended restarts capture at slot 0 bit 0. The partly received slot is discarded, and words from slots already completed are kept.
- R13: After reset `m_valid`, `dma_req` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| cfg_pol | input | 1 | Sampling edge: 0 falling, 1 rising |
| cfg_long_sync | input | 1 | 1 selects long frame sync |
| cfg_early | input | 1 | Short-sync alignment: 1 sync on bit 0, 0 sync one bit before |
| cfg_left_just | input | 1 | 1 takes the word from the start of the slot |
| cfg_slot_len | input | 2 | Slot length code |
| cfg_word_len | input | 3 | Word length code |
| cfg_slots | input | 4 | Slots per frame |
| cfg_quarter | input | 1 | DMA threshold: 0 half, 1 quarter |
| bclk_in | input | 1 | Serial bit clock |
| fsync_in | input | 1 | Frame sync |
| sdata_in | input | 1 | Serial data |
| m_valid | output | 1 | FIFO holds a word |
| m_ready | input | 1 | Consumer takes the word |
| m_data | output | 32 | Oldest word |
| dma_req | output | 1 | Fill level at or above threshold |
| overflow | output | 1 | Sticky word-loss flag |

## Verification
Frames are sent with random filler bits in the unused part of every slot, so a wrong mask or a wrong justification shows up as a data mismatch. Frames are tried with each sampling polarity and with early short, late short and long sync. A one-bit misalignment between the early and late modes moves every word by one bit, and the long-sync run keeps `cfg_early` set to show that the flag has no effect. Slot/word pairs include a narrow word in a wide slot, a word as long as its slot, and a word longer than its slot, which separates the cut-to-slot behaviour from plain shifting. Disabled frames, sync-less bit streams, trailing junk after the last slot and a sync mid-frame show that only framed data is taken. A held-off consumer fills the FIFO across both thresholds, to exactly full and then beyond.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_RUN  = 2'd2
  } rx_state_e;

  function automatic logic [5:0] slot_bits(input logic [1:0] code);
    case (code)
      2'd0:    slot_bits = 6'd8;
      2'd1:    slot_bits = 6'd16;
      default: slot_bits = 6'd32;
    endcase
  endfunction

  function automatic logic [5:0] word_bits(input logic [2:0] code);
    case (code)
      3'd0:    word_bits = 6'd8;
      3'd1:    word_bits = 6'd16;
      3'd2:    word_bits = 6'd20;
      3'd3:    word_bits = 6'd24;
      default: word_bits = 6'd32;
    endcase
  endfunction

  // Places the justified word of a finished slot at the top of a 32-bit word.
  function automatic logic [WORD_W-1:0] align_word(input logic [WORD_W-1:0] sh,
                                                   input logic [5:0] sbits,
                                                   input logic [5:0] wbits,
                                                   input logic left);
    logic [5:0]        weff;
    logic [WORD_W-1:0] keep;
    weff = (wbits > sbits) ? sbits : wbits;
    keep = {WORD_W{1'b1}} << (6'd32 - weff);
    if (left) align_word = (sh << (6'd32 - sbits)) & keep;
    else      align_word = sh << (6'd32 - weff);
  endfunction

endpackage

// File: rtl/tdm_rx_edge.sv
module tdm_rx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pol,
  input  logic bclk_in,
  input  logic fsync_in,
  input  logic sdata_in,
  output logic sample_ev,
  output logic fs_smp,
  output logic sd_smp
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] b_sync, f_sync, d_sync;
  logic         b_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_sync <= '0;
      f_sync <= '0;
      d_sync <= '0;
      b_last <= 1'b0;
    end else begin
      b_sync <= {b_sync[TOP-1:0], bclk_in};
      f_sync <= {f_sync[TOP-1:0], fsync_in};
      d_sync <= {d_sync[TOP-1:0], sdata_in};
      b_last <= b_sync[TOP];
    end
  end

  assign sample_ev = pol ? (b_sync[TOP] & ~b_last) : (~b_sync[TOP] & b_last);
  assign fs_smp    = f_sync[TOP];
  assign sd_smp    = d_sync[TOP];

endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
  import tdm_rx_pkg::*;
#(
  parameter int MAX_SLOTS = 8,
  localparam int SLOT_W = $clog2(MAX_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              long_sync,
  input  logic              early,
  input  logic              left_just,
  input  logic [1:0]        slot_len,
  input  logic [2:0]        word_len,
  input  logic [SLOT_W-1:0] slots,
  input  logic              sample_ev,
  input  logic              fs_smp,
  input  logic              sd_smp,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_data
);
  rx_state_e         state;
  logic              fs_prev;
  logic [5:0]        bit_idx;
  logic [SLOT_W-1:0] slot_idx;
  logic [WORD_W-1:0] shreg;

  logic              fs_start, arm, restart, take;
  logic [5:0]        sbits, wbits, nbits;
  logic [SLOT_W-1:0] nslot, last_slot;
  logic [WORD_W-1:0] nshreg;

  always_comb begin
    sbits     = slot_bits(slot_len);
    wbits     = word_bits(word_len);
    last_slot = (slots == '0) ? '0 : slots - 1'b1;
    fs_start  = fs_smp & ~fs_prev;
    arm       = fs_start & ~long_sync & ~early;
    restart   = (fs_start & ~arm) | (~fs_start & (state == ST_LEAD));
    take      = restart | (~fs_start & (state == ST_RUN));
    nbits     = restart ? 6'd0 : bit_idx;
    nslot     = restart ? '0 : slot_idx;
    nshreg    = restart ? {{(WORD_W-1){1'b0}}, sd_smp} : {shreg[WORD_W-2:0], sd_smp};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      fs_prev   <= 1'b0;
      bit_idx   <= '0;
      slot_idx  <= '0;
      shreg     <= '0;
      word_vld  <= 1'b0;
      word_data <= '0;
    end else begin
      word_vld <= 1'b0;
      if (sample_ev) fs_prev <= fs_smp;
      if (!en) begin
        state <= ST_IDLE;
      end else if (sample_ev) begin
        if (take) begin
          shreg <= nshreg;
          if (nbits == sbits - 6'd1) begin
            bit_idx   <= '0;
            word_vld  <= 1'b1;
            word_data <= align_word(nshreg, sbits, wbits, left_just);
            if (nslot == last_slot) begin
              state    <= ST_IDLE;
              slot_idx <= '0;
            end else begin
              state    <= ST_RUN;
              slot_idx <= nslot + 1'b1;
            end
          end else begin
            bit_idx  <= nbits + 6'd1;
            slot_idx <= nslot;
            state    <= ST_RUN;
          end
        end else if (arm) begin
          state <= ST_LEAD;
        end
      end
    end
  end

endmodule

// File: rtl/tdm_rx_fifo.sv
module tdm_rx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          quarter,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [W-1:0]  rd_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          dma_req,
  output logic          overflow
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [LW-1:0] THR_HALF = LW'(DEPTH / 2);
  localparam logic [LW-1:0] THR_QTR  = LW'(DEPTH / 4);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push, pop;

  assign full     = (level == FULL_LVL);
  assign rd_valid = (level != '0);
  assign rd_data  = mem[rd_ptr];
  assign push     = wr_en & ~full;
  assign pop      = rd_valid & rd_ready;
  assign dma_req  = level >= (quarter ? THR_QTR : THR_HALF);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (wr_en && full) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
  import tdm_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_SLOTS   = 8,
  parameter int FIFO_DEPTH  = 32,
  localparam int SLOT_W = $clog2(MAX_SLOTS + 1),
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              cfg_pol,
  input  logic              cfg_long_sync,
  input  logic              cfg_early,
  input  logic              cfg_left_just,
  input  logic [1:0]        cfg_slot_len,
  input  logic [2:0]        cfg_word_len,
  input  logic [SLOT_W-1:0] cfg_slots,
  input  logic              cfg_quarter,
  input  logic              bclk_in,
  input  logic              fsync_in,
  input  logic              sdata_in,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [WORD_W-1:0] m_data,
  output logic              dma_req,
  output logic              overflow
);
  logic              sample_ev, fs_smp, sd_smp;
  logic              word_vld;
  logic [WORD_W-1:0] word_data;
  logic [LVL_W-1:0]  fifo_level;
  logic              fifo_full;

  tdm_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pol(cfg_pol),
    .bclk_in(bclk_in), .fsync_in(fsync_in), .sdata_in(sdata_in),
    .sample_ev(sample_ev), .fs_smp(fs_smp), .sd_smp(sd_smp)
  );

  tdm_rx_framer #(.MAX_SLOTS(MAX_SLOTS)) u_framer (
    .clk(clk), .rst_n(rst_n), .en(rx_en),
    .long_sync(cfg_long_sync), .early(cfg_early), .left_just(cfg_left_just),
    .slot_len(cfg_slot_len), .word_len(cfg_word_len), .slots(cfg_slots),
    .sample_ev(sample_ev), .fs_smp(fs_smp), .sd_smp(sd_smp),
    .word_vld(word_vld), .word_data(word_data)
  );

  tdm_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(word_vld), .wr_data(word_data),
    .quarter(cfg_quarter), .rd_valid(m_valid), .rd_ready(m_ready),
    .rd_data(m_data), .level(fifo_level), .full(fifo_full),
    .dma_req(dma_req), .overflow(overflow)
  );

endmodule

// File: rtl/tdm_rx_chk.sv
module tdm_rx_chk #(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          m_valid,
  input logic          m_ready,
  input logic [31:0]   m_data,
  input logic          overflow,
  input logic          word_vld,
  input logic          sample_ev,
  input logic          full,
  input logic [LW-1:0] level,
  input logic          dma_req
);
  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R11
  drop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && full) |=> overflow);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R7
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !word_vld);

  // R1
  word_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(sample_ev));

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R10
  dma_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (level >= LW'(DEPTH / 4)));

endmodule

bind tdm_rx tdm_rx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .overflow(overflow),
  .word_vld(word_vld), .sample_ev(sample_ev), .full(fifo_full),
  .level(fifo_level), .dma_req(dma_req)
);

// File: tb/tdm_rx_bench.sv
`timescale 1ns/1ps
module tdm_rx_bench;
  localparam int HB = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, rx_en, cfg_pol, cfg_long_sync, cfg_early, cfg_left_just, cfg_quarter;
  logic [1:0] cfg_slot_len;
  logic [2:0] cfg_word_len;
  logic [3:0] cfg_slots;
  logic bclk_in, fsync_in, sdata_in, m_ready;
  logic m_valid, dma_req, overflow;
  logic [31:0] m_data;

  tdm_rx u_tdm_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_pol(cfg_pol),
    .cfg_long_sync(cfg_long_sync), .cfg_early(cfg_early),
    .cfg_left_just(cfg_left_just), .cfg_slot_len(cfg_slot_len),
    .cfg_word_len(cfg_word_len), .cfg_slots(cfg_slots), .cfg_quarter(cfg_quarter),
    .bclk_in(bclk_in), .fsync_in(fsync_in), .sdata_in(sdata_in),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .dma_req(dma_req), .overflow(overflow)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R13";
  logic [31:0] exp_q[$];
  int unsigned seed = 32'h1234_5678;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: every word handed over is compared against the predicted order.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && m_valid === 1'b1 && m_ready === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected word actual=%h expected=none", cur_req, m_data);
      end else begin
        if (m_data !== exp_q[0]) begin
          fails++;
          $display("FAIL %s word actual=%h expected=%h", cur_req, m_data, exp_q[0]);
        end
        void'(exp_q.pop_front());
      end
    end
  end

  function automatic logic [31:0] nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[15:0], seed[31:16]} ^ (seed >> 7);
  endfunction

  function automatic int sbits();
    return (cfg_slot_len == 2'd0) ? 8 : (cfg_slot_len == 2'd1) ? 16 : 32;
  endfunction

  function automatic int wbits();
    case (cfg_word_len)
      3'd0: return 8;
      3'd1: return 16;
      3'd2: return 20;
      3'd3: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic drive_bit(logic d, logic f);
    #1;
    sdata_in = d; fsync_in = f; bclk_in = cfg_pol ? 1'b0 : 1'b1;
    repeat (HB) @(posedge clk);
    #1;
    bclk_in = cfg_pol ? 1'b1 : 1'b0;
    repeat (HB) @(posedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic push_exp(logic [31:0] w);
    if (exp_q.size() >= 32 && m_ready == 1'b0) return;
    exp_q.push_back(w);
  endtask

  // nsl slots; max_bits < 0 sends every slot bit; trail adds junk bits after.
  task automatic send_frame(int nsl, int gap, bit sync, int max_bits, bit expect_words, bit trail);
    int s_b, w_b, we, nb;
    bit late_short, early_short;
    logic [63:0] wmask, smask, fill_mask;
    logic [31:0] val, junk, slotv;
    s_b = sbits(); w_b = wbits(); we = (w_b > s_b) ? s_b : w_b;
    late_short  = !cfg_long_sync && !cfg_early;
    early_short = !cfg_long_sync && cfg_early;
    wmask = (64'd1 << we) - 1;
    smask = (64'd1 << s_b) - 1;
    for (int g = 0; g < gap; g++)
      drive_bit(nxt() & 1, sync && late_short && (g == gap - 1));
    nb = 0;
    for (int s = 0; s < nsl; s++) begin
      val  = nxt() & wmask[31:0];
      junk = nxt();
      if (cfg_left_just) begin
        fill_mask = (64'd1 << (s_b - we)) - 1;
        slotv = (val << (s_b - we)) | (junk & fill_mask[31:0]);
      end else begin
        slotv = val | ((junk << we) & smask[31:0]);
      end
      for (int b = s_b - 1; b >= 0; b--) begin
        if (max_bits < 0 || nb < max_bits) begin
          drive_bit(slotv[b], sync && (s == 0) &&
                    (cfg_long_sync || (early_short && b == s_b - 1)));
          nb++;
        end
      end
      if (expect_words && (max_bits < 0 || (s + 1) * s_b <= max_bits))
        push_exp(val << (32 - we));
    end
    if (trail)
      for (int t = 0; t < 10; t++) drive_bit(nxt() & 1, 1'b0);
    idle(40);
  endtask

  task automatic setup(logic pol, logic lng, logic erl, logic lj,
                       logic [1:0] sl, logic [2:0] wl, logic [3:0] n);
    @(posedge clk); #1;
    cfg_pol = pol; cfg_long_sync = lng; cfg_early = erl; cfg_left_just = lj;
    cfg_slot_len = sl; cfg_word_len = wl; cfg_slots = n;
    fsync_in = 1'b0; bclk_in = pol;
    idle(10);
  endtask

  task automatic drained(string req);
    check(req, exp_q.size(), 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; m_ready = 1'b1; cfg_quarter = 1'b0;
    cfg_pol = 1'b0; cfg_long_sync = 1'b0; cfg_early = 1'b1; cfg_left_just = 1'b1;
    cfg_slot_len = 2'd1; cfg_word_len = 3'd1; cfg_slots = 4'd2;
    bclk_in = 1'b0; fsync_in = 1'b0; sdata_in = 1'b0;
    idle(5);
    #1 rst_n = 1'b1;
    idle(2);
    // R13 reset state
    check("R13 m_valid", m_valid, 0);
    check("R13 dma_req", dma_req, 0);
    check("R13 overflow", overflow, 0);

    // R7: disabled and then sync-less bits are ignored
    cur_req = "R7";
    setup(0, 0, 1, 1, 2'd1, 3'd1, 4'd2);
    send_frame(2, 2, 1, -1, 0, 1);
    check("R7 disabled", m_valid, 0);
    @(posedge clk); #1 rx_en = 1'b1;
    send_frame(2, 2, 0, -1, 0, 1);
    check("R7 no sync yet", m_valid, 0);
    send_frame(2, 2, 1, -1, 1, 1);
    drained("R7 first framed words");

    // R1 R2 R6: falling edge, 16-bit slots, early short sync
    cur_req = "R1 R2 R6 early short";
    for (int f = 0; f < 3; f++) send_frame(2, 2, 1, -1, 1, 1);
    drained("R6 early short");

    // R1 R4 R6: rising edge, late short sync, 24-bit word right in 32-bit slot
    cur_req = "R1 R4 R6 late short";
    setup(1, 0, 0, 0, 2'd2, 3'd3, 4'd4);
    for (int f = 0; f < 2; f++) send_frame(4, 2, 1, -1, 1, 1);
    drained("R4 right justify");

    // R5 R6: long sync with early set, 8 slots of 8 bits
    cur_req = "R5 R6 long sync";
    setup(0, 1, 1, 1, 2'd0, 3'd0, 4'd8);
    for (int f = 0; f < 2; f++) send_frame(8, 2, 1, -1, 1, 1);
    drained("R6 long sync");

    // R3 R4 R8: 20-bit word left in 32-bit slot, 6 slots
    cur_req = "R3 R4 R8 left 20in32";
    setup(1, 0, 1, 1, 2'd2, 3'd2, 4'd6);
    send_frame(6, 2, 1, -1, 1, 1);
    drained("R8 msb aligned");

    // R3: 32-bit word code in a 16-bit slot is cut to 16
    cur_req = "R3 clamp";
    setup(0, 0, 0, 0, 2'd1, 3'd4, 4'd2);
    send_frame(2, 2, 1, -1, 1, 1);
    drained("R3 clamp");

    // R5: single slot, trailing bits ignored
    cur_req = "R5 one slot";
    setup(0, 0, 1, 0, 2'd1, 3'd0, 4'd1);
    for (int f = 0; f < 3; f++) send_frame(1, 2, 1, -1, 1, 1);
    drained("R5 one slot");

    // R12: sync mid-frame restarts slot 0
    cur_req = "R12 resync";
    setup(0, 0, 1, 1, 2'd0, 3'd0, 4'd4);
    send_frame(4, 2, 1, 12, 1, 0);
    send_frame(4, 1, 1, -1, 1, 1);
    drained("R12 resync");

    // R10 R11: thresholds and overflow with held consumer
    cur_req = "R9 R10 R11 fill";
    @(posedge clk); #1 m_ready = 1'b0; cfg_quarter = 1'b1;
    send_frame(4, 2, 1, -1, 1, 1);
    check("R10 quarter below", dma_req, 0);
    check("R9 valid held", m_valid, 1);
    send_frame(4, 2, 1, -1, 1, 1);
    check("R10 quarter reached", dma_req, 1);
    @(posedge clk); #1 cfg_quarter = 1'b0;
    idle(2);
    check("R10 half below", dma_req, 0);
    send_frame(4, 2, 1, -1, 1, 1);
    send_frame(4, 2, 1, -1, 1, 1);
    check("R10 half reached", dma_req, 1);
    for (int f = 0; f < 4; f++) send_frame(4, 2, 1, -1, 1, 1);
    check("R11 exactly full", overflow, 0);
    send_frame(4, 2, 1, -1, 1, 1);
    check("R11 overflow set", overflow, 1);
    @(posedge clk); #1 m_ready = 1'b1;
    idle(80);
    drained("R9 R11 drain order");
    check("R11 sticky", overflow, 1);
    check("R10 empty", dma_req, 0);

    // R13: reset clears the sticky flag
    @(posedge clk); #1 rst_n = 1'b0;
    idle(2);
    #1 rst_n = 1'b1;
    idle(2);
    check("R13 overflow cleared", overflow, 0);
    check("R13 empty", m_valid, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule